// File: doc/BRIEF.md
# Bus-Organized Register File Datapath

This block is the execution core of a small register-based processor. It holds seven general registers. Two read selectors place operands on an A bus and a B bus. A single shared ALU combines them, and a destination decoder writes the result back. One control word is applied per clock, so every clock edge retires exactly one microoperation. The sequencer that produces the control words is outside this block.

The ALU result is visible combinationally on the output bus in the same cycle the control word is presented. At the clock edge the result is loaded into the selected destination register, if there is one. A four-bit status register captures the carry, sign, zero and overflow conditions of the result. When the function code is not one of the defined operations, the ALU passes the A operand through and leaves the status register unchanged.

Top module: `regbus_datapath`

## Requirements
- R1: The 14-bit control word ctrl_word is split into four fields: bits [13:11] select the A operand, bits [10:8] select the B operand, bits [7:5] select the destination, and bits [4:0] give the ALU function.
- R2: On either operand selector, code 0 places ext_in on that bus, and codes 1 to 7 place register R1 to R7 on it.
- R3: A destination code of 0 writes no register. Codes 1 to 7 load R1 to R7 with the ALU result at the rising clock edge, and all other registers keep their values.
- R4: The 8-bit result (modulo 256) follows the function code: 00000 gives A, 00001 gives A+1, 00010 gives A+B, 00101 gives A-B, 00110 gives A-1, 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, 01110 gives NOT A, 10000 gives A shifted right by one with 0 entering the MSB, and 11000 gives A shifted left by one with 0 entering the LSB.
- R5: Any other function code places A on out_bus, still writes the selected destination with it, and leaves flags unchanged at the clock edge.
- R6: For a defined function, the status register is loaded at the clock edge. flags[1] (zero) is set when the result is all zeros, and flags[2] (sign) equals the result MSB.
- R7: flags[0] (carry) is the carry out of the MSB for increment and add. For subtract and decrement it is the carry out of A + ~B + 1 and A + 8'hFF respectively, so a value of 1 means no borrow. For shift right it is the old A[0], and for shift left it is the old A[7]. It is 0 for pass, AND, OR, XOR and NOT.
- R8: flags[3] (overflow) is the XOR of the carry into and the carry out of the MSB for increment, add, subtract and decrement, and 0 for all other functions.
- R9: XOR with the same register on both selectors, written back to that register, clears that register to zero.
- R10: With rst_n low at a rising clock edge, all seven registers and flags become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 14 | Microoperation control word |
| ext_in | input | 8 | External input word, selectable on either bus |
| out_bus | output | 8 | Combinational ALU result |
| flags | output | 4 | Status: [3] overflow, [2] sign, [1] zero, [0] carry |

## Verification
The assertions check the following on every cycle: the zero and sign flags agree with the previous cycle's result whenever a defined function ran, the status register holds across undefined codes, the external input reaches the output bus on a pass, a written register reads back its value in the following cycle, and reset clears the flags. Only the directed scenarios can show the arithmetic values themselves. This covers the exact carry and overflow for each arithmetic function at its boundaries (0x7F+0x7F, 0x80-0x7F, decrementing zero), the shift-out bits, the self-XOR clear, and the fact that a zero destination leaves every register intact.

// File: rtl/regbus_pkg.sv
// Package: shared function codes and status layout for the register bus datapath.
// Assumes a 5-bit function field; flag bit order is fixed by the port contract.
package regbus_pkg;

    typedef enum logic [4:0] {
        OP_PASS = 5'b00000,
        OP_INC  = 5'b00001,
        OP_ADD  = 5'b00010,
        OP_SUB  = 5'b00101,
        OP_DEC  = 5'b00110,
        OP_AND  = 5'b01000,
        OP_OR   = 5'b01010,
        OP_XOR  = 5'b01100,
        OP_NOT  = 5'b01110,
        OP_SHR  = 5'b10000,
        OP_SHL  = 5'b11000
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic carry;
    } status_t;

endpackage

// File: rtl/regbus_rdmux.sv
// Operand selector: code 0 picks the external word, code k picks register k.
// Assumes registers are packed R1 at the lowest slice of regs_flat.
module regbus_rdmux #(
    parameter int DW   = 8,
    parameter int NREG = 7,
    parameter int SELW = 3
) (
    input  logic [SELW-1:0]    sel,
    input  logic [DW-1:0]      ext_in,
    input  logic [NREG*DW-1:0] regs_flat,
    output logic [DW-1:0]      bus
);

    // Priority-free one-hot style selection over the register slices.
    always_comb begin
        bus = ext_in;
        for (int i = 1; i <= NREG; i++) begin
            if (sel == SELW'(i)) bus = regs_flat[(i-1)*DW +: DW];
        end
    end

endmodule

// File: rtl/regbus_regs.sv
// General register bank with a destination decoder; code 0 writes nothing.
// Assumes synchronous active-low reset clearing every register.
module regbus_regs #(
    parameter int DW   = 8,
    parameter int NREG = 7,
    parameter int SELW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SELW-1:0]    wr_sel,
    input  logic [DW-1:0]      wr_data,
    output logic [NREG*DW-1:0] regs_flat
);

    logic [NREG-1:0] wr_en;

    // Destination decode: one enable per register, none for code 0.
    always_comb begin
        for (int i = 0; i < NREG; i++) wr_en[i] = (wr_sel == SELW'(i + 1));
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        // Storage element for register g+1.
        always_ff @(posedge clk) begin
            if (!rst_n)        q <= '0;
            else if (wr_en[g]) q <= wr_data;
        end
        assign regs_flat[g*DW +: DW] = q;
    end

endmodule

// File: rtl/regbus_alu.sv
// Shared ALU: one adder serves inc/add/sub/dec; logic and shift ops beside it.
// Assumes DW >= 2; undefined codes pass A and report op_ok = 0.
module regbus_alu
    import regbus_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OPW = 5
) (
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [OPW-1:0] opr,
    output logic [DW-1:0]  result,
    output status_t        status,
    output logic           op_ok
);

    logic [DW-1:0] add_b;
    logic          add_cin;
    logic          use_add;
    logic [DW:0]   sum_full;
    logic [DW-1:0] sum_low;
    logic          c_out;
    logic          v_out;

    // Adder operand choice for the arithmetic functions.
    always_comb begin
        add_b   = '0;
        add_cin = 1'b0;
        use_add = 1'b1;
        case (opr)
            OP_INC:  begin add_b = '0; add_cin = 1'b1; end
            OP_ADD:  begin add_b = b;  add_cin = 1'b0; end
            OP_SUB:  begin add_b = ~b; add_cin = 1'b1; end
            OP_DEC:  begin add_b = '1; add_cin = 1'b0; end
            default: use_add = 1'b0;
        endcase
    end

    assign sum_full = {1'b0, a} + {1'b0, add_b} + {{DW{1'b0}}, add_cin};
    assign sum_low  = {1'b0, a[DW-2:0]} + {1'b0, add_b[DW-2:0]} + {{(DW-1){1'b0}}, add_cin};

    // Result and carry/overflow selection per function.
    always_comb begin
        result = a;
        c_out  = 1'b0;
        v_out  = 1'b0;
        op_ok  = 1'b1;
        if (use_add) begin
            result = sum_full[DW-1:0];
            c_out  = sum_full[DW];
            v_out  = sum_low[DW-1] ^ sum_full[DW];
        end else begin
            case (opr)
                OP_PASS: result = a;
                OP_AND:  result = a & b;
                OP_OR:   result = a | b;
                OP_XOR:  result = a ^ b;
                OP_NOT:  result = ~a;
                OP_SHR:  begin result = {1'b0, a[DW-1:1]}; c_out = a[0]; end
                OP_SHL:  begin result = {a[DW-2:0], 1'b0}; c_out = a[DW-1]; end
                default: begin result = a; op_ok = 1'b0; end
            endcase
        end
    end

    // Status assembly from the chosen result.
    always_comb begin
        status.ovf   = v_out;
        status.sign  = result[DW-1];
        status.zero  = (result == '0);
        status.carry = c_out;
    end

endmodule

// File: rtl/regbus_datapath.sv
// Top: register bank, two operand selectors, shared ALU and status register.
// One control word per clock; out_bus is combinational, writes and flags at the edge.
module regbus_datapath
    import regbus_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 7,
    parameter int SELW = 3,
    parameter int OPW  = 5,
    localparam int CWW = 3 * SELW + OPW,
    localparam int FW  = $bits(status_t)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CWW-1:0] ctrl_word,
    input  logic [DW-1:0]  ext_in,
    output logic [DW-1:0]  out_bus,
    output logic [FW-1:0]  flags
);

    logic [SELW-1:0]    sel_a, sel_b, sel_d;
    logic [OPW-1:0]     opr;
    logic [NREG*DW-1:0] regs_flat;
    logic [DW-1:0]      bus_a, bus_b, alu_res;
    status_t            alu_stat;
    logic               alu_ok;
    status_t            stat_q;

    assign sel_a = ctrl_word[CWW-1 -: SELW];
    assign sel_b = ctrl_word[CWW-1-SELW -: SELW];
    assign sel_d = ctrl_word[OPW +: SELW];
    assign opr   = ctrl_word[OPW-1:0];

    regbus_regs #(.DW(DW), .NREG(NREG), .SELW(SELW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_sel(sel_d), .wr_data(alu_res), .regs_flat(regs_flat)
    );

    regbus_rdmux #(.DW(DW), .NREG(NREG), .SELW(SELW)) u_mux_a (
        .sel(sel_a), .ext_in(ext_in), .regs_flat(regs_flat), .bus(bus_a)
    );

    regbus_rdmux #(.DW(DW), .NREG(NREG), .SELW(SELW)) u_mux_b (
        .sel(sel_b), .ext_in(ext_in), .regs_flat(regs_flat), .bus(bus_b)
    );

    regbus_alu #(.DW(DW), .OPW(OPW)) u_alu (
        .a(bus_a), .b(bus_b), .opr(opr), .result(alu_res), .status(alu_stat), .op_ok(alu_ok)
    );

    // Status register: loads only on defined functions.
    always_ff @(posedge clk) begin
        if (!rst_n)      stat_q <= '0;
        else if (alu_ok) stat_q <= alu_stat;
    end

    assign out_bus = alu_res;
    assign flags   = stat_q;

endmodule

// File: rtl/regbus_datapath_chk.sv
// Checker: temporal properties of the datapath ports, bound to the top.
module regbus_datapath_chk #(
    parameter int DW  = 8,
    parameter int CWW = 14,
    parameter int FW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [CWW-1:0] ctrl_word,
    input logic [DW-1:0]  ext_in,
    input logic [DW-1:0]  out_bus,
    input logic [FW-1:0]  flags
);

    logic [2:0] f_a, f_d;
    logic [4:0] f_op;
    logic       f_known;

    assign f_a  = ctrl_word[13:11];
    assign f_d  = ctrl_word[7:5];
    assign f_op = ctrl_word[4:0];
    assign f_known = f_op inside {5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110,
                                  5'b01000, 5'b01010, 5'b01100, 5'b01110, 5'b10000, 5'b11000};

    a_r10_reset_clears: assert property (@(posedge clk) !rst_n |=> flags == '0);

    a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !f_known |=> $stable(flags));

    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        f_known |=> flags[1] == ($past(out_bus) == '0));

    a_r6_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        f_known |=> flags[2] == $past(out_bus[DW-1]));

    a_r2_ext_path: assert property (@(posedge clk) disable iff (!rst_n)
        (f_a == 3'd0 && f_op == 5'b00000) |-> out_bus == ext_in);

    a_r3_write_back: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(f_d) != 3'd0 && f_a == $past(f_d) && f_op == 5'b00000)
        |-> out_bus == $past(out_bus));

endmodule

bind regbus_datapath regbus_datapath_chk #(.DW(DW), .CWW(CWW), .FW(FW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ext_in(ext_in),
    .out_bus(out_bus), .flags(flags)
);

// File: tb/regbus_datapath_tb.sv
module regbus_datapath_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ctrl_word = '0;
    logic [7:0]  ext_in = '0;
    logic [7:0]  out_bus;
    logic [3:0]  flags;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    localparam logic [4:0] PASS = 5'b00000, INC = 5'b00001, ADD = 5'b00010, SUB = 5'b00101,
                           DEC = 5'b00110, ANDO = 5'b01000, ORO = 5'b01010, XORO = 5'b01100,
                           NOTO = 5'b01110, SHR = 5'b10000, SHL = 5'b11000, BAD = 5'b00011;

    always #5 clk = ~clk;

    regbus_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ext_in(ext_in),
        .out_bus(out_bus), .flags(flags)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One microoperation: check out_bus before the edge, optionally flags after it.
    task automatic step(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                        input logic [4:0] op, input logic [7:0] ext, input logic [7:0] exp_out,
                        input bit do_f, input logic [3:0] exp_f, input string req);
        @(negedge clk);
        ctrl_word = {sa, sb, sd, op};
        ext_in = ext;
        #2;
        check(req, out_bus, exp_out);
        @(posedge clk);
        #1;
        if (do_f) check(req, {4'b0, flags}, {4'b0, exp_f});
    endtask

    task automatic read_reg(input logic [2:0] r, input logic [7:0] exp, input string req);
        step(r, 3'd0, 3'd0, PASS, 8'h00, exp, 0, 4'b0, req);
    endtask

    task automatic t_reset;
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1;
        check("R10 flags", {4'b0, flags}, 8'h00);
        @(negedge clk);
        rst_n = 1;
        for (int r = 1; r <= 7; r++) read_reg(3'(r), 8'h00, "R10 reg");
    endtask

    task automatic t_load;
        step(3'd0, 3'd0, 3'd1, PASS, 8'h35, 8'h35, 1, 4'b0000, "R2 load R1");
        step(3'd0, 3'd0, 3'd2, PASS, 8'h0F, 8'h0F, 0, 4'b0, "R2 load R2");
        step(3'd0, 3'd0, 3'd3, PASS, 8'h80, 8'h80, 1, 4'b0100, "R6 load R3 sign");
        step(3'd0, 3'd0, 3'd4, PASS, 8'h7F, 8'h7F, 0, 4'b0, "R1 load R4");
        read_reg(3'd1, 8'h35, "R3 R1 readback");
        read_reg(3'd3, 8'h80, "R3 R3 readback");
    endtask

    task automatic t_arith;
        step(3'd1, 3'd2, 3'd5, ADD, 8'h00, 8'h44, 1, 4'b0000, "R4 add");
        read_reg(3'd5, 8'h44, "R3 R5 written");
        step(3'd4, 3'd4, 3'd6, ADD, 8'h00, 8'hFE, 1, 4'b1100, "R8 add overflow");
        step(3'd3, 3'd4, 3'd0, SUB, 8'h00, 8'h01, 1, 4'b1001, "R7 sub no borrow, R8 ovf");
        step(3'd2, 3'd1, 3'd0, SUB, 8'h00, 8'hDA, 1, 4'b0100, "R7 sub borrow");
        step(3'd4, 3'd0, 3'd4, INC, 8'h00, 8'h80, 1, 4'b1100, "R8 inc overflow");
        read_reg(3'd4, 8'h80, "R4 inc written");
        step(3'd7, 3'd0, 3'd0, DEC, 8'h00, 8'hFF, 1, 4'b0100, "R7 dec of zero");
        step(3'd1, 3'd0, 3'd0, DEC, 8'h00, 8'h34, 1, 4'b0001, "R7 dec no borrow");
        step(3'd1, 3'd0, 3'd0, ADD, 8'h01, 8'h36, 1, 4'b0000, "R2 ext on B bus");
    endtask

    task automatic t_logic;
        step(3'd1, 3'd2, 3'd0, ANDO, 8'h00, 8'h05, 1, 4'b0000, "R4 and");
        step(3'd1, 3'd2, 3'd0, ORO, 8'h00, 8'h3F, 0, 4'b0, "R4 or");
        step(3'd1, 3'd2, 3'd0, XORO, 8'h00, 8'h3A, 0, 4'b0, "R4 xor");
        step(3'd1, 3'd0, 3'd0, NOTO, 8'h00, 8'hCA, 1, 4'b0100, "R4 not");
    endtask

    task automatic t_shift;
        step(3'd3, 3'd0, 3'd0, SHR, 8'h00, 8'h40, 1, 4'b0000, "R7 shr msb");
        step(3'd1, 3'd0, 3'd0, SHR, 8'h00, 8'h1A, 1, 4'b0001, "R7 shr carry");
        step(3'd3, 3'd0, 3'd0, SHL, 8'h00, 8'h00, 1, 4'b0011, "R7 shl carry zero");
    endtask

    task automatic t_undefined;
        step(3'd1, 3'd0, 3'd7, BAD, 8'h00, 8'h35, 1, 4'b0011, "R5 flags held");
        read_reg(3'd7, 8'h35, "R5 write of A");
    endtask

    task automatic t_selfclear;
        step(3'd2, 3'd2, 3'd2, XORO, 8'h00, 8'h00, 1, 4'b0010, "R9 self xor");
        read_reg(3'd2, 8'h00, "R9 cleared");
    endtask

    task automatic t_nowrite;
        step(3'd0, 3'd0, 3'd0, PASS, 8'hAA, 8'hAA, 0, 4'b0, "R3 no-dest pass");
        read_reg(3'd1, 8'h35, "R3 R1 kept");
        read_reg(3'd5, 8'h44, "R3 R5 kept");
        read_reg(3'd7, 8'h35, "R3 R7 kept");
    endtask

    task automatic t_midreset;
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        #1;
        check("R10 mid flags", {4'b0, flags}, 8'h00);
        @(negedge clk);
        rst_n = 1;
        read_reg(3'd1, 8'h00, "R10 mid R1");
        read_reg(3'd5, 8'h00, "R10 mid R5");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_load();
        t_arith();
        t_logic();
        t_shift();
        t_undefined();
        t_selfclear();
        t_nowrite();
        t_midreset();
        finish_run();
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule